// File: doc/BRIEF.md
# DRAM ECC Error Capture and Signalling Unit

This unit sits beside the ECC checker of a DRAM controller and keeps a record of the errors that checker reports. The checker drives one-cycle event pulses: one for a correctable (single-bit) error and one for an uncorrectable (multi-bit) error. Alongside the pulses it drives the failing address, the channel, the 8-bit syndrome and a destination code. Three more pulses report a refresh timeout, a lock error on a non-DRAM target and a thermal sensor trip. Software reads the record through a small word-addressed register port and clears status bits by writing ones to them.

Only one error record is kept. An uncorrectable error takes over a record that holds only a correctable error. Any other error that arrives while a record is held leaves the record alone. Three command registers each route status bits to one of three outgoing one-cycle notification pulses. System software is expected to enable only one of the three paths.

The internal reset is asserted asynchronously by `rst_n` and released two clock edges after `rst_n` rises.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads zero and all three notification outputs are low.
- R2: The status register at offset 0x00 sets bit 0 on a correctable event, bit 1 on an uncorrectable event, bit 8 on a refresh timeout, bit 9 on a non-DRAM lock error and bit 11 on a thermal event. The change is visible the cycle after the event pulse. All other bits read zero.
- R3: Writing to offset 0x00 clears every implemented status bit whose write-data bit is 1. Bits written with 0 are left unchanged.
- R4: If a status clear and a new event for the same bit fall in the same cycle, the bit stays set.
- R5: Offset 0x04 returns event address bits 31:7 in bits 31:7, zero in bits 6:1 and the channel in bit 0. Offset 0x08 returns event address bit 32 in bit 0, with the upper bits zero.
- R6: Offset 0x0C returns the syndrome of the held record, zero-extended. Offset 0x10 returns its destination code, zero-extended.
- R7: A correctable event that arrives while status bit 0 or bit 1 is set leaves the address, channel, syndrome and destination unchanged.
- R8: An uncorrectable event that arrives while status bit 1 is clear replaces the held details, even if a correctable record is held. Both bits then stay set. A later uncorrectable event while bit 1 is set changes nothing. A simultaneous correctable and uncorrectable event keeps the shared event data.
- R9: The command registers are at offsets 0x14 (error line), 0x18 (management interrupt) and 0x1C (OS interrupt). The first keeps written bits 0, 1, 8, 9 and 11. The other two keep only bits 0 and 1. Unkept bits read zero.
- R10: Each notification output pulses high for exactly one cycle, in the same cycle the new status becomes visible. It pulses only when a status bit goes from 0 to 1 and that bit is set in the output's command register as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_evt | input | 1 | Correctable error pulse |
| ue_evt | input | 1 | Uncorrectable error pulse |
| refto_evt | input | 1 | Refresh timeout pulse |
| lock_evt | input | 1 | Non-DRAM lock error pulse |
| therm_evt | input | 1 | Thermal sensor event pulse |
| evt_addr | input | 33 | Byte address of the failing access |
| evt_chan | input | 1 | Channel of the failing access |
| evt_syn | input | 8 | ECC syndrome |
| evt_dest | input | 8 | Destination code (0 means processor read) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| err_line_o | output | 1 | Error-line notification pulse |
| mgmt_int_o | output | 1 | Management interrupt pulse |
| os_int_o | output | 1 | OS interrupt pulse |

## Verification
The bench checks the overwrite rules. A second correctable error must not disturb a held record, and a design that captured it would show the wrong syndrome. An uncorrectable error must take over a correctable record, and a design that ignored it would keep the stale address. A clear that lands in the same cycle as a new event must leave the bit set; a design that let the clear win would drop that error. The notification pulses are checked for being repeated on an already-set bit, for lasting more than one cycle, and for leaking to a path whose command bit is clear.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;

  localparam int REG_W = 32;
  localparam int ST_W  = 16;

  localparam int ST_CE    = 0;
  localparam int ST_UE    = 1;
  localparam int ST_REFTO = 8;
  localparam int ST_LOCK  = 9;
  localparam int ST_THERM = 11;

  localparam logic [ST_W-1:0] ST_IMPL_MASK = 16'h0B03;
  localparam logic [ST_W-1:0] ECC_ONLY_MASK = 16'h0003;

  localparam int NUM_PATHS = 3;

  // register select, decoded from byte offset bits 4:2
  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_ADDR   = 3'd1,
    SEL_XADDR  = 3'd2,
    SEL_SYN    = 3'd3,
    SEL_DEST   = 3'd4,
    SEL_CMD0   = 3'd5,
    SEL_CMD1   = 3'd6,
    SEL_CMD2   = 3'd7
  } reg_sel_e;

endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/ecc_log_status.sv
module ecc_log_status #(
  parameter int              ST_W      = 16,
  parameter logic [ST_W-1:0] IMPL_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] set_i,
  input  logic [ST_W-1:0] clr_i,
  output logic [ST_W-1:0] st_q,
  output logic [ST_W-1:0] st_d
);
  for (genvar i = 0; i < ST_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic b_q;
      logic b_d;
      logic b_en;

      // a set in the same cycle as a clear wins
      always_comb begin
        b_en = set_i[i] | clr_i[i];
        b_d  = set_i[i] | (b_q & ~clr_i[i]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    b_q <= 1'b0;
        else if (b_en) b_q <= b_d;
      end

      assign st_q[i] = b_q;
      assign st_d[i] = b_en ? b_d : b_q;
    end else begin : g_rsvd
      assign st_q[i] = 1'b0;
      assign st_d[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture #(
  parameter int LINE_AW = 26,
  parameter int SYN_W   = 8,
  parameter int DEST_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce_evt,
  input  logic               ue_evt,
  input  logic               ce_held,
  input  logic               ue_held,
  input  logic [LINE_AW-1:0] line_i,
  input  logic               chan_i,
  input  logic [SYN_W-1:0]   syn_i,
  input  logic [DEST_W-1:0]  dest_i,
  output logic [LINE_AW-1:0] line_q,
  output logic               chan_q,
  output logic [SYN_W-1:0]   syn_q,
  output logic [DEST_W-1:0]  dest_q
);
  logic               cap_en;
  logic [LINE_AW-1:0] line_d;
  logic               chan_d;
  logic [SYN_W-1:0]   syn_d;
  logic [DEST_W-1:0]  dest_d;

  // uncorrectable takes over anything short of a held uncorrectable record;
  // correctable only fills an empty record
  always_comb begin
    cap_en = (ue_evt & ~ue_held) | (ce_evt & ~ce_held & ~ue_held);
    line_d = line_i;
    chan_d = chan_i;
    syn_d  = syn_i;
    dest_d = dest_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      chan_q <= 1'b0;
      syn_q  <= '0;
      dest_q <= '0;
    end else if (cap_en) begin
      line_q <= line_d;
      chan_q <= chan_d;
      syn_q  <= syn_d;
      dest_q <= dest_d;
    end
  end
endmodule

// File: rtl/ecc_log_notify.sv
module ecc_log_notify #(
  parameter int              CMD_W = 16,
  parameter logic [CMD_W-1:0] MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wdata,
  input  logic [CMD_W-1:0] rise_i,
  output logic [CMD_W-1:0] cmd_q,
  output logic             pulse_q
);
  logic [CMD_W-1:0] cmd_d;
  logic             pulse_d;

  always_comb begin
    cmd_d   = wdata & MASK;
    pulse_d = |(rise_i & cmd_q & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cmd_q <= '0;
    else if (wr_en) cmd_q <= cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_err_log_pkg::*;
#(
  parameter int ADDR_W     = 33,
  parameter int LINE_SHIFT = 7,
  parameter int SYN_W      = 8,
  parameter int DEST_W     = 8,
  parameter int REG_AW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_evt,
  input  logic              ue_evt,
  input  logic              refto_evt,
  input  logic              lock_evt,
  input  logic              therm_evt,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              evt_chan,
  input  logic [SYN_W-1:0]  evt_syn,
  input  logic [DEST_W-1:0] evt_dest,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              err_line_o,
  output logic              mgmt_int_o,
  output logic              os_int_o
);
  localparam int LINE_AW = ADDR_W - LINE_SHIFT;
  localparam int XW      = ADDR_W - REG_W;
  localparam int LO_LINE = REG_W - LINE_SHIFT;
  localparam logic [ST_W-1:0] PATH_MASK [NUM_PATHS] =
    '{ST_IMPL_MASK, ECC_ONLY_MASK, ECC_ONLY_MASK};

  logic               rst_n_s;
  logic               sel_ok;
  reg_sel_e           sel;
  logic [ST_W-1:0]    set_vec;
  logic [ST_W-1:0]    clr_vec;
  logic [ST_W-1:0]    st_q;
  logic [ST_W-1:0]    st_d;
  logic [ST_W-1:0]    rise_vec;
  logic [LINE_AW-1:0] line_q;
  logic               chan_q;
  logic [SYN_W-1:0]   syn_q;
  logic [DEST_W-1:0]  dest_q;
  logic [ST_W-1:0]    cmd_q   [NUM_PATHS];
  logic [NUM_PATHS-1:0] pulse_vec;
  logic [NUM_PATHS-1:0] cmd_wr;
  logic               unused_ok;

  assign unused_ok = ^{reg_wdata[REG_W-1:ST_W], evt_addr[LINE_SHIFT-1:0]};

  ecc_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  // register decode
  always_comb begin
    sel_ok  = (reg_addr[REG_AW-1:5] == '0) && (reg_addr[1:0] == 2'b00);
    sel     = reg_sel_e'(reg_addr[4:2]);
    clr_vec = (reg_wr && sel_ok && sel == SEL_STATUS) ? reg_wdata[ST_W-1:0] : '0;
    cmd_wr  = '0;
    if (reg_wr && sel_ok) begin
      cmd_wr[0] = (sel == SEL_CMD0);
      cmd_wr[1] = (sel == SEL_CMD1);
      cmd_wr[2] = (sel == SEL_CMD2);
    end
  end

  always_comb begin
    set_vec           = '0;
    set_vec[ST_CE]    = ce_evt;
    set_vec[ST_UE]    = ue_evt;
    set_vec[ST_REFTO] = refto_evt;
    set_vec[ST_LOCK]  = lock_evt;
    set_vec[ST_THERM] = therm_evt;
  end

  ecc_log_status #(
    .ST_W      (ST_W),
    .IMPL_MASK (ST_IMPL_MASK)
  ) u_status (
    .clk   (clk),
    .rst_n (rst_n_s),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .st_q  (st_q),
    .st_d  (st_d)
  );

  assign rise_vec = st_d & ~st_q;

  ecc_log_capture #(
    .LINE_AW (LINE_AW),
    .SYN_W   (SYN_W),
    .DEST_W  (DEST_W)
  ) u_capture (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ce_evt  (ce_evt),
    .ue_evt  (ue_evt),
    .ce_held (st_q[ST_CE]),
    .ue_held (st_q[ST_UE]),
    .line_i  (evt_addr[ADDR_W-1:LINE_SHIFT]),
    .chan_i  (evt_chan),
    .syn_i   (evt_syn),
    .dest_i  (evt_dest),
    .line_q  (line_q),
    .chan_q  (chan_q),
    .syn_q   (syn_q),
    .dest_q  (dest_q)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
    ecc_log_notify #(
      .CMD_W (ST_W),
      .MASK  (PATH_MASK[p])
    ) u_notify (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .wr_en   (cmd_wr[p]),
      .wdata   (reg_wdata[ST_W-1:0]),
      .rise_i  (rise_vec),
      .cmd_q   (cmd_q[p]),
      .pulse_q (pulse_vec[p])
    );
  end

  assign err_line_o = pulse_vec[0];
  assign mgmt_int_o = pulse_vec[1];
  assign os_int_o   = pulse_vec[2];

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (sel_ok) begin
      unique case (sel)
        SEL_STATUS: reg_rdata = REG_W'(st_q);
        SEL_ADDR:   reg_rdata = {line_q[LO_LINE-1:0], {(LINE_SHIFT-1){1'b0}}, chan_q};
        SEL_XADDR:  reg_rdata = REG_W'(line_q[LINE_AW-1 -: XW]);
        SEL_SYN:    reg_rdata = REG_W'(syn_q);
        SEL_DEST:   reg_rdata = REG_W'(dest_q);
        SEL_CMD0:   reg_rdata = REG_W'(cmd_q[0]);
        SEL_CMD1:   reg_rdata = REG_W'(cmd_q[1]);
        SEL_CMD2:   reg_rdata = REG_W'(cmd_q[2]);
        default:    reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int SYN_W = 8
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             ce_evt,
  input logic             ue_evt,
  input logic [SYN_W-1:0] evt_syn,
  input logic [15:0]      st_q,
  input logic [SYN_W-1:0] syn_q,
  input logic             err_line_o,
  input logic             mgmt_int_o,
  input logic             os_int_o
);
  // R4: a correctable event always leaves its status bit set
  a_r4_ce_event_wins: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) && $past(ce_evt) |-> st_q[0]);

  // R7: held details stay put when only a correctable error arrives
  a_r7_ce_keeps_record: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) && ($past(st_q[0]) || $past(st_q[1])) && !$past(ue_evt)
    |-> $stable(syn_q));

  // R8: uncorrectable error takes the record unless one is held
  a_r8_ue_takes_record: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) && $past(ue_evt) && !$past(st_q[1])
    |-> (syn_q == $past(evt_syn)) && st_q[1]);

  // R10: a pulse only follows a status bit going from 0 to 1
  a_r10_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n_s)
    (err_line_o || mgmt_int_o || os_int_o) |-> ((st_q & ~$past(st_q)) != 16'h0));

  // R10: no pulse while status holds still
  a_r10_quiet_when_stable: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) && $stable(st_q) |-> !err_line_o && !mgmt_int_o && !os_int_o);
endmodule

bind ecc_err_log ecc_err_log_chk #(.SYN_W(SYN_W)) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .ce_evt     (ce_evt),
  .ue_evt     (ue_evt),
  .evt_syn    (evt_syn),
  .st_q       (st_q),
  .syn_q      (syn_q),
  .err_line_o (err_line_o),
  .mgmt_int_o (mgmt_int_o),
  .os_int_o   (os_int_o)
);

// File: tb/test_ecc_err_log.sv
`timescale 1ns/1ps
module test_ecc_err_log;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_evt, ue_evt, refto_evt, lock_evt, therm_evt;
  logic [32:0] evt_addr;
  logic        evt_chan;
  logic [7:0]  evt_syn, evt_dest;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        err_line_o, mgmt_int_o, os_int_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit [15:0] m_st;
  bit [25:0] m_line;
  bit        m_chan;
  bit [7:0]  m_syn, m_dest;
  bit [15:0] m_cmd [3];
  bit [2:0]  m_pulse;
  bit        m_s1, m_s2;

  always #2.5 clk = ~clk;

  ecc_err_log i_ecc_err_log (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ue_evt(ue_evt),
    .refto_evt(refto_evt), .lock_evt(lock_evt), .therm_evt(therm_evt),
    .evt_addr(evt_addr), .evt_chan(evt_chan), .evt_syn(evt_syn), .evt_dest(evt_dest),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_line_o(err_line_o), .mgmt_int_o(mgmt_int_o), .os_int_o(os_int_o)
  );

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic model_step();
    bit [15:0] old, nw, clr, setv;
    bit [15:0] mask [3];
    mask[0] = 16'h0B03; mask[1] = 16'h0003; mask[2] = 16'h0003;
    if (!rst_n) begin
      m_st = 0; m_line = 0; m_chan = 0; m_syn = 0; m_dest = 0;
      m_cmd[0] = 0; m_cmd[1] = 0; m_cmd[2] = 0; m_pulse = 0; m_s1 = 0; m_s2 = 0;
      return;
    end
    if (m_s2) begin
      old  = m_st;
      clr  = (reg_wr && reg_addr == 8'h00) ? (reg_wdata[15:0] & 16'h0B03) : 16'h0;
      setv = 0;
      setv[0] = ce_evt; setv[1] = ue_evt; setv[8] = refto_evt; setv[9] = lock_evt; setv[11] = therm_evt;
      nw = (old & ~clr) | setv;
      if ((ue_evt && !old[1]) || (ce_evt && old[1:0] == 2'b00)) begin
        m_line = evt_addr[32:7]; m_chan = evt_chan; m_syn = evt_syn; m_dest = evt_dest;
      end
      for (int k = 0; k < 3; k++) m_pulse[k] = ((nw & ~old & m_cmd[k]) != 0);
      for (int k = 0; k < 3; k++)
        if (reg_wr && reg_addr == 8'h14 + 8'(4*k)) m_cmd[k] = reg_wdata[15:0] & mask[k];
      m_st = nw;
    end
    m_s2 = m_s1;
    m_s1 = 1'b1;
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return {16'h0, m_st};
      8'h04: return {m_line[24:0], 6'b0, m_chan};
      8'h08: return {31'h0, m_line[25]};
      8'h0C: return {24'h0, m_syn};
      8'h10: return {24'h0, m_dest};
      8'h14: return {16'h0, m_cmd[0]};
      8'h18: return {16'h0, m_cmd[1]};
      8'h1C: return {16'h0, m_cmd[2]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic compare_all();
    logic [7:0] keep;
    keep = reg_addr;
    chk({29'h0, os_int_o, mgmt_int_o, err_line_o}, {29'h0, m_pulse[2], m_pulse[1], m_pulse[0]}, cur_req, "pulses");
    for (int k = 0; k < 8; k++) begin
      reg_addr = 8'(4*k);
      #0.1;
      chk(reg_rdata, m_read(reg_addr), cur_req, $sformatf("reg %h", reg_addr));
    end
    reg_addr = keep;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_in();
    ce_evt = 0; ue_evt = 0; refto_evt = 0; lock_evt = 0; therm_evt = 0;
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #0.1;
    chk(reg_rdata, exp, req, $sformatf("direct read %h", a));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_wr = 0;
  endtask

  task automatic ev(input bit ce, input bit ue, input logic [32:0] a, input bit ch,
                    input logic [7:0] s, input logic [7:0] d);
    ce_evt = ce; ue_evt = ue; evt_addr = a; evt_chan = ch; evt_syn = s; evt_dest = d;
    cyc();
    ce_evt = 0; ue_evt = 0;
  endtask

  task automatic pulses_chk(input bit e, input bit m, input bit o, input string req);
    chk({29'h0, os_int_o, mgmt_int_o, err_line_o}, {29'h0, o, m, e}, req, "notification outputs");
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; reg_addr = 0; evt_addr = 0; evt_chan = 0; evt_syn = 0; evt_dest = 0;
    idle_in();
    @(negedge clk);
    cur_req = "R1";
    repeat (3) cyc();
    rst_n = 1;
    repeat (4) cyc();
    for (int k = 0; k < 8; k++) rd_chk(8'(4*k), 32'h0, "R1");
    pulses_chk(0, 0, 0, "R1");

    cur_req = "R9";
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'h0000_FFFF);
    wr(8'h1C, 32'h0000_0000);
    rd_chk(8'h14, 32'h0000_0B03, "R9");
    rd_chk(8'h18, 32'h0000_0003, "R9");
    rd_chk(8'h1C, 32'h0, "R9");

    cur_req = "R2";
    ev(1, 0, 33'h1_2345_67FF, 1, 8'hA5, 8'h00);
    pulses_chk(1, 1, 0, "R10");
    rd_chk(8'h00, 32'h0000_0001, "R2");
    rd_chk(8'h04, 32'h2345_6781, "R5");
    rd_chk(8'h08, 32'h0000_0001, "R5");
    rd_chk(8'h0C, 32'h0000_00A5, "R6");
    rd_chk(8'h10, 32'h0000_0000, "R6");
    cyc();
    pulses_chk(0, 0, 0, "R10");

    cur_req = "R7";
    ev(1, 0, 33'h0_1111_1100, 0, 8'h11, 8'h01);
    pulses_chk(0, 0, 0, "R10");
    rd_chk(8'h0C, 32'h0000_00A5, "R7");
    rd_chk(8'h04, 32'h2345_6781, "R7");

    cur_req = "R8";
    ev(0, 1, 33'h0_ABCD_E000, 0, 8'h3C, 8'h02);
    pulses_chk(1, 1, 0, "R10");
    rd_chk(8'h00, 32'h0000_0003, "R8");
    rd_chk(8'h04, 32'hABCD_E000, "R8");
    rd_chk(8'h08, 32'h0, "R8");
    rd_chk(8'h0C, 32'h0000_003C, "R8");
    rd_chk(8'h10, 32'h0000_0002, "R8");
    ev(0, 1, 33'h1_0000_0080, 1, 8'h77, 8'h05);
    rd_chk(8'h0C, 32'h0000_003C, "R8");
    rd_chk(8'h04, 32'hABCD_E000, "R8");
    ev(1, 0, 33'h0_2222_2200, 1, 8'h22, 8'h03);
    rd_chk(8'h0C, 32'h0000_003C, "R7");

    cur_req = "R3";
    wr(8'h00, 32'h0);
    rd_chk(8'h00, 32'h0000_0003, "R3");
    wr(8'h00, 32'h1);
    rd_chk(8'h00, 32'h0000_0002, "R3");
    wr(8'h00, 32'h2);
    rd_chk(8'h00, 32'h0, "R3");

    cur_req = "R4";
    ev(1, 0, 33'h0_0000_1000, 0, 8'h99, 8'h00);
    reg_wr = 1; reg_addr = 8'h00; reg_wdata = 32'h1; ce_evt = 1;
    cyc();
    reg_wr = 0; ce_evt = 0;
    pulses_chk(0, 0, 0, "R4");
    rd_chk(8'h00, 32'h0000_0001, "R4");
    wr(8'h00, 32'h1);

    cur_req = "R2";
    refto_evt = 1; cyc(); refto_evt = 0;
    pulses_chk(1, 0, 0, "R10");
    rd_chk(8'h00, 32'h0000_0100, "R2");
    lock_evt = 1; therm_evt = 1; cyc(); lock_evt = 0; therm_evt = 0;
    rd_chk(8'h00, 32'h0000_0B00, "R2");

    cur_req = "R10";
    wr(8'h14, 32'h0);
    wr(8'h18, 32'h0);
    wr(8'h00, 32'hFFFF);
    rd_chk(8'h00, 32'h0, "R3");
    ev(1, 0, 33'h0_0000_2000, 0, 8'h44, 8'h00);
    pulses_chk(0, 0, 0, "R10");
    wr(8'h00, 32'h3);
    wr(8'h1C, 32'h2);
    ev(1, 1, 33'h1_8000_0000, 1, 8'h5A, 8'h07);
    pulses_chk(0, 0, 1, "R10");
    rd_chk(8'h00, 32'h0000_0003, "R8");
    rd_chk(8'h0C, 32'h0000_005A, "R8");
    rd_chk(8'h08, 32'h0000_0001, "R5");
    repeat (3) cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule